// File: doc/BRIEF.md
# Output Word Format Converter

This stage takes one wide signed fixed-point sample per handshake and re-expresses it in one of four output formats picked by a 2-bit selector. It delivers the result as a 32-bit word that is aligned to the most significant bit, together with a count of the bits that a downstream serializer should shift out. The available forms are:

- plain truncation of the word;
- rounding to 16 bits or to 24 bits, saturating at the largest positive value;
- a compact float made of an 8-bit signed mantissa and a 4-bit exponent.

In every form except truncation, all word bits outside the active field are zero.

Samples enter on a valid/ready interface and leave on another one, with one register in the path. A sample is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its converted word is presented with `out_valid` high from the next cycle on. While `out_valid` is high and `out_ready` is low, the word and the length stay frozen and `in_ready` is low. This back-pressure passes upstream in the same cycle, and no sample is dropped or duplicated. The format select is sampled together with the data, so changing it during a stall does not alter a word that is waiting at the output.

Top module: `owf_conv`

## Requirements
- R1: While reset is held and right after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Format code 0 outputs the top 32 bits of the sample unchanged, and `out_len` is 8.
- R3: Format code 1 places the sample rounded to 16 bits in `out_word[31:16]`, makes `out_word[15:0]` zero, and sets `out_len` to 16.
- R4: Format code 2 places the sample rounded to 24 bits in `out_word[31:8]`, makes `out_word[7:0]` zero, and sets `out_len` to 24.
- R5: Rounding adds one half of the kept LSB and truncates. A sum beyond the largest positive value gives that value (0x7FFF or 0x7FFFFF) instead of wrapping.
- R6: Format code 3 gives a float with `out_len` 12. The exponent in `out_word[23:20]` is the number of redundant sign bits below the MSB, clamped to 15. The mantissa in `out_word[31:24]` is the 8 top bits of the sample after a left shift by that exponent. `out_word[19:0]` is zero.
- R7: A zero sample in format code 3 gives an all-zero `out_word`.
- R8: A sample accepted on one edge appears with `out_valid` high after the next edge (one-cycle latency).
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_word` and `out_len` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Stage can accept a sample |
| in_sample | input | IN_W | Signed fixed-point sample, two's complement |
| in_fmt | input | 2 | Format code: 0 trunc, 1 round-16, 2 round-24, 3 float |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_word | output | 32 | Converted word, aligned to the MSB |
| out_len | output | 5 | Number of bits for the serializer (8, 16, 24 or 12) |

## Verification
The bench builds the block with the default IN_W of 40. At that width, truncation drops eight real low bits, and the rounding bit sits well inside the sample for both rounding widths. Float exponents from 0 up to the clamp at 15 are also reachable, since any magnitude below about 2^24 saturates the count. Stimulus mixes directed corners (the largest and smallest values, ±1, zero, and values one step below a rounding carry) with random samples that are arithmetically shifted down to spread out the redundant sign bit count. Random valid and ready patterns exercise stalls in which the format selector changes underneath a held word.

// File: rtl/owf_pkg.sv
package owf_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 5;
  localparam int MANT_W = 8;
  localparam int EXP_W  = 4;
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  typedef enum logic [1:0] {
    FMT_TRUNC8 = 2'd0,
    FMT_RND16  = 2'd1,
    FMT_RND24  = 2'd2,
    FMT_FLOAT  = 2'd3
  } fmt_e;
endpackage

// File: rtl/owf_round.sv
module owf_round #(
  parameter int W = 16
) (
  input  logic [W:0]   head,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] kept;
  logic         half;

  always_comb begin
    kept = head[W:1];
    half = head[0];
    if (half && (kept == POS_MAX)) q = POS_MAX;
    else                           q = kept + {{(W-1){1'b0}}, half};
  end
endmodule

// File: rtl/owf_float.sv
module owf_float
  import owf_pkg::*;
#(
  parameter int IN_W = 40
) (
  input  logic [IN_W-1:0]  x,
  output logic [MANT_W-1:0] mant,
  output logic [EXP_W-1:0]  expo
);
  int   cnt;
  logic run;
  int   sh;

  always_comb begin
    cnt = 0;
    run = 1'b1;
    for (int i = IN_W - 2; i >= 0; i--) begin
      if (run && (x[i] == x[IN_W-1])) cnt++;
      else                            run = 1'b0;
    end
    if (x == '0) begin
      expo = '0;
      mant = '0;
      sh   = 0;
    end else begin
      expo = (cnt > EXP_MAX) ? EXP_W'(EXP_MAX) : EXP_W'(cnt);
      sh   = IN_W - MANT_W - int'(expo);
      mant = MANT_W'(x >> sh);
    end
  end
endmodule

// File: rtl/owf_stage.sv
module owf_stage #(
  parameter int W = 37
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/owf_conv.sv
module owf_conv
  import owf_pkg::*;
#(
  parameter int IN_W = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IN_W-1:0] in_sample,
  input  logic [1:0]      in_fmt,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [31:0]     out_word,
  output logic [4:0]      out_len
);
  localparam int R16 = 16;
  localparam int R24 = 24;
  localparam int PACK_W = WORD_W + LEN_W;

  logic [R16-1:0]    rnd16;
  logic [R24-1:0]    rnd24;
  logic [MANT_W-1:0] fmant;
  logic [EXP_W-1:0]  fexp;
  logic [WORD_W-1:0] word_d;
  logic [LEN_W-1:0]  len_d;
  logic [PACK_W-1:0] pack_q;
  fmt_e              fmt;

  owf_round #(.W(R16)) u_rnd16 (.head(in_sample[IN_W-1 -: R16+1]), .q(rnd16));
  owf_round #(.W(R24)) u_rnd24 (.head(in_sample[IN_W-1 -: R24+1]), .q(rnd24));
  owf_float #(.IN_W(IN_W)) u_flt (.x(in_sample), .mant(fmant), .expo(fexp));

  always_comb begin
    fmt = fmt_e'(in_fmt);
    unique case (fmt)
      FMT_TRUNC8: begin
        word_d = in_sample[IN_W-1 -: WORD_W];
        len_d  = LEN_W'(8);
      end
      FMT_RND16: begin
        word_d = {rnd16, {(WORD_W-R16){1'b0}}};
        len_d  = LEN_W'(R16);
      end
      FMT_RND24: begin
        word_d = {rnd24, {(WORD_W-R24){1'b0}}};
        len_d  = LEN_W'(R24);
      end
      default: begin
        word_d = {fmant, fexp, {(WORD_W-MANT_W-EXP_W){1'b0}}};
        len_d  = LEN_W'(MANT_W + EXP_W);
      end
    endcase
  end

  owf_stage #(.W(PACK_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  ({word_d, len_d}),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (pack_q)
  );

  assign out_word = pack_q[PACK_W-1 -: WORD_W];
  assign out_len  = pack_q[LEN_W-1:0];
endmodule

// File: rtl/owf_conv_chk.sv
module owf_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_word,
  input logic [4:0]  out_len
);
  // R8: accepted sample is visible one cycle later
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9: stalled output holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_len)));

  // R9: no acceptance while a stalled word waits
  a_r9_block: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R3: low half clear in 16-bit rounding
  a_r3_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == 5'd16) |-> (out_word[15:0] == 16'h0));

  // R4: low byte clear in 24-bit rounding
  a_r4_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == 5'd24) |-> (out_word[7:0] == 8'h0));

  // R6: float tail clear
  a_r6_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == 5'd12) |-> (out_word[19:0] == 20'h0));

  // R2: only the four legal lengths appear
  a_r2_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len == 5'd8 || out_len == 5'd12 ||
                   out_len == 5'd16 || out_len == 5'd24));
endmodule

bind owf_conv owf_conv_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_word (out_word),
  .out_len  (out_len)
);

// File: tb/owf_conv_tb.sv
module owf_conv_tb;
  localparam int IN_W = 40;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [IN_W-1:0] in_sample = '0;
  logic [1:0]      in_fmt = 2'd0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [31:0]     out_word;
  logic [4:0]      out_len;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // model state
  bit          m_valid = 1'b0;
  logic [31:0] m_word = '0;
  logic [4:0]  m_len = '0;
  string       m_tag = "R2";
  bit          stalled = 1'b0;

  always #5 clk = ~clk;

  owf_conv #(.IN_W(IN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .in_fmt(in_fmt), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .out_len(out_len)
  );

  function automatic longint sx(logic [IN_W-1:0] d);
    logic signed [IN_W-1:0] s;
    longint v;
    s = d;
    v = s;
    return v;
  endfunction

  function automatic longint rnd(longint v, int w);
    int s;
    longint q;
    longint mx;
    s = IN_W - w;
    q = (v + (64'sd1 <<< (s - 1))) >>> s;
    mx = (64'sd1 <<< (w - 1)) - 1;
    if (q > mx) q = mx;
    return q;
  endfunction

  task automatic expect_of(input logic [IN_W-1:0] d, input logic [1:0] f,
                           output logic [31:0] w, output logic [4:0] l,
                           output string tag);
    longint v;
    longint q;
    longint lim;
    int e;
    v = sx(d);
    case (f)
      2'd0: begin
        q = v >>> (IN_W - 32);
        w = q[31:0]; l = 5'd8; tag = "R2";
      end
      2'd1: begin
        q = rnd(v, 16);
        w = {q[15:0], 16'h0}; l = 5'd16;
        tag = (q == 64'sd32767) ? "R5" : "R3";
      end
      2'd2: begin
        q = rnd(v, 24);
        w = {q[23:0], 8'h0}; l = 5'd24;
        tag = (q == 64'sd8388607) ? "R5" : "R4";
      end
      default: begin
        l = 5'd12;
        if (v == 0) begin
          w = '0; tag = "R7";
        end else begin
          lim = 64'sd1 <<< (IN_W - 1);
          e = 0;
          while (e < 15 && (v * 2) >= -lim && (v * 2) < lim) begin
            v = v * 2;
            e++;
          end
          q = v >>> (IN_W - 8);
          w = {q[7:0], 4'(e), 20'h0};
          tag = "R6";
        end
      end
    endcase
  endtask

  task automatic check_outputs();
    bit exp_ready;
    exp_ready = !m_valid || out_ready;
    total++;
    if (out_valid !== m_valid) begin
      bad++;
      $display("FAIL R8 out_valid actual=%0b expected=%0b", out_valid, m_valid);
    end
    total++;
    if (in_ready !== exp_ready) begin
      bad++;
      $display("FAIL R9 in_ready actual=%0b expected=%0b", in_ready, exp_ready);
    end
    if (m_valid) begin
      total++;
      if (out_word !== m_word || out_len !== m_len) begin
        bad++;
        $display("FAIL %s%s word actual=%h/%0d expected=%h/%0d",
                 m_tag, stalled ? " R9" : "", out_word, out_len, m_word, m_len);
      end
    end
  endtask

  task automatic step();
    logic [31:0] w;
    logic [4:0]  l;
    string t;
    @(posedge clk);
    stalled = m_valid && !out_ready;
    if (!m_valid || out_ready) begin
      if (in_valid) begin
        expect_of(in_sample, in_fmt, w, l, t);
        m_word = w; m_len = l; m_tag = t;
      end
      m_valid = in_valid;
    end
    @(negedge clk);
    check_outputs();
  endtask

  task automatic send(input logic [IN_W-1:0] d, input logic [1:0] f,
                      input bit v, input bit r);
    in_sample = d; in_fmt = f; in_valid = v; out_ready = r;
    step();
  endtask

  function automatic logic [IN_W-1:0] rand_sample();
    logic [63:0] r;
    logic signed [IN_W-1:0] s;
    r = {$urandom, $urandom};
    s = r[IN_W-1:0];
    if ($urandom % 2 == 0) s = s >>> ($urandom % IN_W);
    return s;
  endfunction

  initial begin
    logic [IN_W-1:0] corners [10];
    corners[0] = {1'b0, {(IN_W-1){1'b1}}};
    corners[1] = {1'b1, {(IN_W-1){1'b0}}};
    corners[2] = '0;
    corners[3] = '1;
    corners[4] = IN_W'(1);
    corners[5] = {16'h7FFF, 1'b1, {(IN_W-17){1'b0}}};
    corners[6] = {16'h7FFE, 1'b1, {(IN_W-17){1'b0}}};
    corners[7] = {24'h7FFFFF, 1'b1, {(IN_W-25){1'b0}}};
    corners[8] = {16'hFFFF, 1'b0, {(IN_W-17){1'b1}}};
    corners[9] = IN_W'(40'h00_0012_3456);

    repeat (3) @(negedge clk);
    // R1: state while reset is held
    total++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      bad++;
      $display("FAIL R1 reset actual=%0b/%0b expected=0/1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      bad++;
      $display("FAIL R1 after reset actual=%0b/%0b expected=0/1", out_valid, in_ready);
    end

    // directed corners in every format, free-flowing
    for (int c = 0; c < 10; c++)
      for (int f = 0; f < 4; f++)
        send(corners[c], 2'(f), 1'b1, 1'b1);

    // stall with format and data changing underneath (R9)
    send(corners[9], 2'd3, 1'b1, 1'b1);
    send(corners[0], 2'd1, 1'b1, 1'b0);
    send(corners[1], 2'd0, 1'b1, 1'b0);
    send(corners[3], 2'd2, 1'b1, 1'b0);
    send(corners[3], 2'd2, 1'b0, 1'b1);

    // random traffic
    for (int k = 0; k < 4000; k++)
      send(rand_sample(), 2'($urandom % 4), ($urandom % 10) < 7, ($urandom % 10) < 7);
    send('0, 2'd0, 1'b0, 1'b1);
    send('0, 2'd0, 1'b0, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule